// File: doc/BRIEF.md
# Multi-Character Word Serial Receiver

This block turns an asynchronous serial line into parallel characters. One received word opens with a single low start bit. It then carries one to eight characters back to back, with no start or stop bits between them, each 5 to 8 bits long and sent least significant bit first. An optional parity bit follows, and the word closes with a high stop bit. The parity bit is either appended after the last character or sent in place of that character's final data bit. Each character goes into a one-entry holding register as soon as its last bit has been sampled. The host reads that register with a read strobe.

The line is sampled on a bit-rate enable. That enable is either a 16x oversampling tick, with each bit sampled at its centre, or a 1x tick on which every pulse is one bit sample. The block keeps sticky flags for parity error, overrun, framing error and break detect. It also drives a first-character flag while a multi-character word is still being received. A receive-enable input gates the whole receiver.

Top module: `mcw_rx_top`

## Requirements
- R1: With `len_sel` s (0..3) each character is 5+s bits long and with `cnt_sel` k (0..7) a word holds k+1 characters. Bits arrive least significant first after one low start bit, and each character appears right-aligned in `hold_data` with its unused upper bits at 0.
- R2: With `par_en`=1 and `par_inside`=0 the parity bit follows the last character as an extra bit. With `par_inside`=1 the parity value takes the last data bit position of the last character, and that bit is delivered in `hold_data` as received.
- R3: `rx_ready` rises one clock after the sample of a character's last bit and falls one clock after a `hold_read` pulse when no new character arrives. In 16x mode, with a tick on every clock, a 5-bit character's `rx_ready` is first seen 89 clocks after the start edge. After reset `rx_ready`, `first_char` and all flags are 0.
- R4: In a word of two or more characters `first_char` is 1 from the delivery of the first character until the stop-bit sample. It stays 0 for single-character words.
- R5: With `par_en`=1, `par_err` is set at the stop sample when the ones count over all data and parity bits of the word is odd with `par_odd`=0, or even with `par_odd`=1.
- R6: `frm_err` is set when the stop-bit sample is low.
- R7: `ovr_err` is set when a character is written while `rx_ready` is still 1 and no `hold_read` comes in that clock. The newer character replaces the older one.
- R8: In 16x mode a low level that is gone by the start bit's centre sample is discarded, and hunting for a start bit resumes.
- R9: A word whose every sample, including parity and stop, is low sets `brk_det` together with `frm_err`. The receiver then ignores the line until it returns high.
- R10: While `rx_enable` is 0 no character is delivered and any word in progress is abandoned.
- R11: With `rate_1x`=0 bits are sampled 8 ticks after the start edge tick and every 16 ticks after that. With `rate_1x`=1 every tick is a sample and the start-detecting tick is the start sample.
- R12: `par_err`, `ovr_err`, `frm_err` and `brk_det` stay 1 until an `err_clear` clock, and a new set in that clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate tick (16x or 1x) |
| rx_in | input | 1 | Serial line, idle high |
| rx_enable | input | 1 | Receiver enable |
| len_sel | input | 2 | Character length select, 5+value bits |
| cnt_sel | input | 3 | Characters per word, value+1 |
| par_en | input | 1 | Parity present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| par_inside | input | 1 | Parity in last data bit of last character |
| rate_1x | input | 1 | 1 = sample on every tick |
| hold_read | input | 1 | Host read strobe for the holding register |
| err_clear | input | 1 | Clears the sticky flags |
| hold_data | output | 8 | Holding register contents |
| rx_ready | output | 1 | Holding register has an unread character |
| first_char | output | 1 | First character of a multi-character word received |
| par_err | output | 1 | Sticky parity error |
| ovr_err | output | 1 | Sticky overrun error |
| frm_err | output | 1 | Sticky framing error |
| brk_det | output | 1 | Sticky break detect |

## Verification
The bench builds the receiver with its default oversampling factor of 16. It drives `rate_1x` itself, so both the 16x centre-sampling path and the 1x path are exercised in one build. Using the 16x default makes the exact 89-clock delivery latency and the rejection of a short low glitch observable at the ports. The stimulus covers all four character lengths and word sizes of 1, 2, 4 and 8 characters, with parity appended and with parity inside the last character. The runs also include a long all-low break and words sent while the receiver is disabled.

// File: rtl/mcw_rx_pkg.sv
package mcw_rx_pkg;

    localparam int DW    = 8;
    localparam int LEN_W = 2;
    localparam int CNT_W = 3;
    localparam int BIT_W = $clog2(DW);
    localparam int NFLG  = 4;

    typedef struct packed {
        logic [LEN_W-1:0] len_sel;
        logic [CNT_W-1:0] cnt_sel;
        logic             par_en;
        logic             par_odd;
        logic             par_inside;
        logic             rate_1x;
    } rx_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRK
    } rx_state_e;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } rx_char_t;

    typedef struct packed {
        logic par;
        logic frm;
        logic brk;
    } rx_err_t;

    function automatic logic [BIT_W:0] char_bits(input logic [LEN_W-1:0] sel);
        return (BIT_W+1)'(DW - (1 << LEN_W) + 1) + (BIT_W+1)'(sel);
    endfunction

endpackage

// File: rtl/mcw_rx_sampler.sv
module mcw_rx_sampler #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line,
    input  logic rate_1x,
    input  logic hunting,
    output logic start_seen,
    output logic smp
);
    localparam int PW = $clog2(OVERSAMPLE);
    localparam logic [PW-1:0] MID  = PW'(OVERSAMPLE / 2 - 1);
    localparam logic [PW-1:0] LAST = PW'(OVERSAMPLE - 1);

    logic [PW-1:0] phase;

    assign start_seen = hunting & tick & ~line;
    assign smp        = ~hunting & tick & (rate_1x | (phase == MID));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (start_seen) begin
            phase <= '0;
        end else if (tick && !hunting) begin
            if (phase == LAST) phase <= '0;
            else               phase <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/mcw_rx_framer.sv
module mcw_rx_framer
    import mcw_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     rx_enable,
    input  rx_cfg_t  cfg,
    input  logic     line,
    input  logic     start_seen,
    input  logic     smp,
    output logic     hunting,
    output rx_char_t chr,
    output rx_err_t  err_set,
    output logic     first_char
);
    rx_state_e        state;
    logic [DW-1:0]    shreg;
    logic [BIT_W-1:0] bit_idx;
    logic [CNT_W-1:0] chr_idx;
    logic             par_acc;
    logic             all_zero;

    logic [BIT_W:0]   nbits;
    logic             last_bit;
    logic             last_chr;
    logic [DW-1:0]    shifted;
    logic             stop_smp;

    assign nbits    = char_bits(cfg.len_sel);
    assign last_bit = ({1'b0, bit_idx} == nbits - 1'b1);
    assign last_chr = (chr_idx == cfg.cnt_sel);
    assign shifted  = {line, shreg[DW-1:1]};
    assign hunting  = (state == ST_IDLE) && rx_enable;
    assign stop_smp = (state == ST_STOP) && smp;

    always_comb begin
        chr.valid   = (state == ST_DATA) && smp && last_bit;
        chr.data    = shifted >> ((BIT_W+1)'(DW) - nbits);
        err_set.frm = stop_smp && !line;
        err_set.brk = stop_smp && !line && all_zero;
        err_set.par = stop_smp && cfg.par_en && (par_acc ^ cfg.par_odd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            shreg      <= '0;
            bit_idx    <= '0;
            chr_idx    <= '0;
            par_acc    <= 1'b0;
            all_zero   <= 1'b1;
            first_char <= 1'b0;
        end else if (!rx_enable) begin
            state      <= ST_IDLE;
            first_char <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_seen) begin
                        state      <= cfg.rate_1x ? ST_DATA : ST_START;
                        bit_idx    <= '0;
                        chr_idx    <= '0;
                        par_acc    <= 1'b0;
                        all_zero   <= 1'b1;
                        first_char <= 1'b0;
                    end
                end
                ST_START: begin
                    if (smp) state <= line ? ST_IDLE : ST_DATA;
                end
                ST_DATA: begin
                    if (smp) begin
                        shreg    <= shifted;
                        par_acc  <= par_acc ^ line;
                        all_zero <= all_zero & ~line;
                        if (last_bit) begin
                            bit_idx <= '0;
                            if (chr_idx == '0 && cfg.cnt_sel != '0) first_char <= 1'b1;
                            if (last_chr)
                                state <= (cfg.par_en && !cfg.par_inside) ? ST_PAR : ST_STOP;
                            else
                                chr_idx <= chr_idx + 1'b1;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end
                end
                ST_PAR: begin
                    if (smp) begin
                        par_acc  <= par_acc ^ line;
                        all_zero <= all_zero & ~line;
                        state    <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (smp) begin
                        first_char <= 1'b0;
                        state      <= (!line && all_zero) ? ST_BRK : ST_IDLE;
                    end
                end
                ST_BRK: begin
                    if (line) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mcw_rx_hold.sv
module mcw_rx_hold
    import mcw_rx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  rx_char_t      chr,
    input  rx_err_t       err_set,
    input  logic          hold_read,
    input  logic          err_clear,
    output logic [DW-1:0] hold_data,
    output logic          rx_ready,
    output logic          par_err,
    output logic          ovr_err,
    output logic          frm_err,
    output logic          brk_det
);
    logic [NFLG-1:0] set_v;
    logic [NFLG-1:0] flg_q;
    logic            ovr_set;

    assign ovr_set = chr.valid && rx_ready && !hold_read;
    assign set_v   = {ovr_set, err_set.brk, err_set.frm, err_set.par};

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_data <= '0;
            rx_ready  <= 1'b0;
        end else if (chr.valid) begin
            hold_data <= chr.data;
            rx_ready  <= 1'b1;
        end else if (hold_read) begin
            rx_ready  <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NFLG; i++) begin
            if (rst) flg_q[i] <= 1'b0;
            else     flg_q[i] <= set_v[i] | (flg_q[i] & ~err_clear);
        end
    end

    assign par_err = flg_q[0];
    assign frm_err = flg_q[1];
    assign brk_det = flg_q[2];
    assign ovr_err = flg_q[3];

endmodule

// File: rtl/mcw_rx_top.sv
module mcw_rx_top
    import mcw_rx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_en,
    input  logic             rx_in,
    input  logic             rx_enable,
    input  logic [LEN_W-1:0] len_sel,
    input  logic [CNT_W-1:0] cnt_sel,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             par_inside,
    input  logic             rate_1x,
    input  logic             hold_read,
    input  logic             err_clear,
    output logic [DW-1:0]    hold_data,
    output logic             rx_ready,
    output logic             first_char,
    output logic             par_err,
    output logic             ovr_err,
    output logic             frm_err,
    output logic             brk_det
);
    rx_cfg_t  cfg;
    rx_char_t chr;
    rx_err_t  err_set;
    logic     hunting;
    logic     start_seen;
    logic     smp;
    logic     chr_valid;

    assign cfg = '{len_sel: len_sel, cnt_sel: cnt_sel, par_en: par_en,
                   par_odd: par_odd, par_inside: par_inside, rate_1x: rate_1x};
    assign chr_valid = chr.valid;

    mcw_rx_sampler #(.OVERSAMPLE(OVERSAMPLE)) i_sampler (
        .clk        (clk),
        .rst        (rst),
        .tick       (bit_en),
        .line       (rx_in),
        .rate_1x    (rate_1x),
        .hunting    (hunting),
        .start_seen (start_seen),
        .smp        (smp)
    );

    mcw_rx_framer i_framer (
        .clk        (clk),
        .rst        (rst),
        .rx_enable  (rx_enable),
        .cfg        (cfg),
        .line       (rx_in),
        .start_seen (start_seen),
        .smp        (smp),
        .hunting    (hunting),
        .chr        (chr),
        .err_set    (err_set),
        .first_char (first_char)
    );

    mcw_rx_hold i_hold (
        .clk       (clk),
        .rst       (rst),
        .chr       (chr),
        .err_set   (err_set),
        .hold_read (hold_read),
        .err_clear (err_clear),
        .hold_data (hold_data),
        .rx_ready  (rx_ready),
        .par_err   (par_err),
        .ovr_err   (ovr_err),
        .frm_err   (frm_err),
        .brk_det   (brk_det)
    );

endmodule

// File: rtl/mcw_rx_checker.sv
module mcw_rx_checker (
    input logic clk,
    input logic rst,
    input logic rx_enable,
    input logic hold_read,
    input logic err_clear,
    input logic chr_valid,
    input logic rx_ready,
    input logic ovr_err,
    input logic frm_err,
    input logic par_err,
    input logic brk_det
);
    p_ready_after_char_r3: assert property (@(posedge clk) disable iff (rst)
        chr_valid |=> rx_ready);

    p_ready_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (rx_ready && hold_read && !chr_valid) |=> !rx_ready);

    p_overrun_set_r7: assert property (@(posedge clk) disable iff (rst)
        (chr_valid && rx_ready && !hold_read) |=> ovr_err);

    p_ovr_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (ovr_err && !err_clear) |=> ovr_err);

    p_frm_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (frm_err && !err_clear) |=> frm_err);

    p_par_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        (par_err && !err_clear) |=> par_err);

    p_break_frames_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_det) |-> frm_err);

    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !rx_enable |=> !chr_valid);

endmodule

bind mcw_rx_top mcw_rx_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_enable (rx_enable),
    .hold_read (hold_read),
    .err_clear (err_clear),
    .chr_valid (chr_valid),
    .rx_ready  (rx_ready),
    .ovr_err   (ovr_err),
    .frm_err   (frm_err),
    .par_err   (par_err),
    .brk_det   (brk_det)
);

// File: tb/test_mcw_rx_top.sv
`timescale 1ns/1ps
module test_mcw_rx_top;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst, bit_en, rx_in, rx_enable, par_en, par_odd, par_inside, rate_1x, err_clear;
    logic       hold_read = 1'b0;
    logic [1:0] len_sel;
    logic [2:0] cnt_sel;
    logic [7:0] hold_data;
    logic       rx_ready, first_char, par_err, ovr_err, frm_err, brk_det;

    logic [1:0] ph = 2'd0;
    int         cyc = 0;
    always @(posedge clk) begin
        ph  <= ph + 2'd1;
        cyc <= cyc + 1;
    end
    assign bit_en = rate_1x ? (ph == 2'd0) : 1'b1;

    mcw_rx_top i_mcw_rx_top (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rx_in(rx_in), .rx_enable(rx_enable),
        .len_sel(len_sel), .cnt_sel(cnt_sel), .par_en(par_en), .par_odd(par_odd),
        .par_inside(par_inside), .rate_1x(rate_1x), .hold_read(hold_read),
        .err_clear(err_clear), .hold_data(hold_data), .rx_ready(rx_ready),
        .first_char(first_char), .par_err(par_err), .ovr_err(ovr_err),
        .frm_err(frm_err), .brk_det(brk_det)
    );

    // capture monitor: reads the holding register whenever auto_read is on
    logic       auto_read = 1'b1;
    int         ncap = 0;
    logic [7:0] cap_d [64];
    logic       cap_fc[64];
    int         cap_cyc[64];
    always @(negedge clk) begin
        if (auto_read && rx_ready && !hold_read) begin
            cap_d[ncap % 64]   = hold_data;
            cap_fc[ncap % 64]  = first_char;
            cap_cyc[ncap % 64] = cyc;
            ncap++;
            hold_read = 1'b1;
        end else begin
            hold_read = 1'b0;
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0]  len;
        logic [2:0]  cnt;
        logic        pe, po, pin, bad_par, bad_stop;
        logic [63:0] data;
        logic        exp_pe, exp_fe;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS[NV] = '{
        '{2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h00000000000000A5, 1'b0, 1'b0},
        '{2'd0, 3'd3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 64'h00000000031F0A15, 1'b0, 1'b0},
        '{2'd1, 3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 64'h000000000000132C, 1'b0, 1'b0},
        '{2'd2, 3'd7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 64'h017F402A5533116E, 1'b1, 1'b0},
        '{2'd3, 3'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 64'h00000000000080C3, 1'b0, 1'b1},
        '{2'd0, 3'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 64'h0000000000000007, 1'b1, 1'b0}
    };

    logic [7:0] exp_c[8];
    int         start_cyc;
    int         base;

    task automatic send_bit(input logic b);
        rx_in = b;
        repeat (rate_1x ? 4 : 16) @(negedge clk);
    endtask

    task automatic send_word(input logic [1:0] len, input logic [2:0] cnt, input logic pe,
                             input logic po, input logic pin, input logic bad_par,
                             input logic bad_stop, input logic [63:0] data);
        int   nb, nc;
        logic x, b;
        len_sel = len; cnt_sel = cnt; par_en = pe; par_odd = po; par_inside = pin;
        nb = 5 + int'(len);
        nc = 1 + int'(cnt);
        x  = 1'b0;
        start_cyc = cyc;
        send_bit(1'b0);
        for (int c = 0; c < nc; c++) begin
            exp_c[c] = 8'h00;
            for (int i = 0; i < nb; i++) begin
                b = data[c*8 + i];
                if (pe && pin && c == nc - 1 && i == nb - 1) b = po ^ x ^ bad_par;
                x = x ^ b;
                exp_c[c][i] = b;
                send_bit(b);
            end
        end
        if (pe && !pin) send_bit(po ^ x ^ bad_par);
        send_bit(!bad_stop);
        send_bit(1'b1);
    endtask

    task automatic clear_errs();
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_all();
        vec_t v;
        rst = 1'b1; rx_in = 1'b1; rx_enable = 1'b1; err_clear = 1'b0; rate_1x = 1'b0;
        len_sel = 2'd0; cnt_sel = 3'd0; par_en = 1'b0; par_odd = 1'b0; par_inside = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3 R12 reset state
        chk({rx_ready, first_char}, 2'b00, "R3 reset ready/first");
        chk({par_err, ovr_err, frm_err, brk_det}, 4'h0, "R12 reset flags");
        repeat (4) @(negedge clk);

        // table-driven words (R1 R2 R4 R5 R6)
        for (int k = 0; k < NV; k++) begin
            v = VECS[k];
            base = ncap;
            send_word(v.len, v.cnt, v.pe, v.po, v.pin, v.bad_par, v.bad_stop, v.data);
            repeat (24) @(negedge clk);
            chk(ncap - base, 1 + int'(v.cnt), "R1 char count");
            for (int c = 0; c <= int'(v.cnt); c++)
                chk(cap_d[(base + c) % 64], exp_c[c], v.pin ? "R2 inside-parity char" : "R1 char data");
            chk(cap_fc[base % 64], v.cnt != 3'd0, "R4 first_char at first char");
            chk(first_char, 1'b0, "R4 first_char after word");
            chk(par_err, v.exp_pe, "R5 parity error");
            chk(frm_err, v.exp_fe, "R6 framing error");
            chk(ovr_err, 1'b0, "R7 no overrun when read");
            clear_errs();
            chk({par_err, frm_err}, 2'b00, "R12 flags cleared");
        end

        // R3 R11 delivery latency in 16x mode
        base = ncap;
        send_word(2'd0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h11);
        chk(cap_cyc[base % 64] - start_cyc, 89, "R3 R11 ready latency");
        chk(cap_d[base % 64], 8'h11, "R11 16x data");

        // R7 overrun and R12 sticky across read
        auto_read = 1'b0;
        send_word(2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h3C);
        send_word(2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'hC3);
        chk(ovr_err, 1'b1, "R7 overrun set");
        chk(hold_data, 8'hC3, "R7 newer char kept");
        base = ncap;
        auto_read = 1'b1;
        repeat (4) @(negedge clk);
        chk(rx_ready, 1'b0, "R3 ready cleared by read");
        chk(ovr_err, 1'b1, "R12 overrun sticky after read");
        clear_errs();
        chk(ovr_err, 1'b0, "R12 overrun cleared");

        // R8 short low glitch rejected
        base = ncap;
        rx_in = 1'b0;
        repeat (5) @(negedge clk);
        rx_in = 1'b1;
        repeat (40) @(negedge clk);
        chk(ncap - base, 0, "R8 glitch gives no char");
        chk(frm_err, 1'b0, "R8 glitch gives no framing error");
        send_word(2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h5A);
        repeat (4) @(negedge clk);
        chk(cap_d[base % 64], 8'h5A, "R8 word after glitch");

        // R9 break: whole word low, then held low
        len_sel = 2'd3; cnt_sel = 3'd1; par_en = 1'b1; par_odd = 1'b0; par_inside = 1'b0;
        base = ncap;
        rx_in = 1'b0;
        repeat (400) @(negedge clk);
        chk(brk_det, 1'b1, "R9 break detected");
        chk(frm_err, 1'b1, "R9 break also framing");
        chk(ncap - base, 2, "R9 no chars while line held low");
        rx_in = 1'b1;
        repeat (32) @(negedge clk);
        base = ncap;
        send_word(2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h99);
        repeat (4) @(negedge clk);
        chk(ncap - base, 1, "R9 resumes after line high");
        chk(cap_d[base % 64], 8'h99, "R9 data after break");
        clear_errs();
        chk(brk_det, 1'b0, "R12 break cleared");

        // R10 disabled receiver
        rx_enable = 1'b0;
        base = ncap;
        send_word(2'd3, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h77);
        repeat (4) @(negedge clk);
        chk(ncap - base, 0, "R10 nothing while disabled");
        chk(rx_ready, 1'b0, "R10 ready stays low");
        rx_enable = 1'b1;
        repeat (20) @(negedge clk);

        // R11 1x sampling
        rate_1x = 1'b1;
        repeat (8) @(negedge clk);
        base = ncap;
        send_word(2'd1, 3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h2516);
        repeat (8) @(negedge clk);
        chk(ncap - base, 2, "R11 1x char count");
        chk(cap_d[base % 64], exp_c[0], "R11 1x char 0");
        chk(cap_d[(base + 1) % 64], exp_c[1], "R11 1x char 1");
        chk({par_err, frm_err}, 2'b00, "R11 1x no errors");
    endtask

    initial begin
        logic wd = 1'b0;
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule